// File: doc/BRIEF.md
# Serial Flash Write-Enable Gate

This block decides, for every command that a serial flash controller has decoded, whether the command may run. The command decoder presents an opcode and a count of clocked bits together with a one-cycle strobe when chip select rises. The gate answers one cycle later with an accept pulse or a reject pulse. When it accepts a data-modifying command, it sends a start pulse and the opcode to the array sequencer. The sequencer reports the end of the operation with a completion pulse.

The gate holds three pieces of state: the write-enable latch, the busy flag and the deep-sleep flag. It forms the 8-bit status byte from the first two. A modifying command runs only when all of these hold:
- the latch is set;
- the bit count is a whole, non-zero number of bytes;
- no operation is in flight;
- a power-up inhibit period, counted in clock cycles after reset release, has expired.

While the deep-sleep flag is set, only the wake-up command is honoured.

Top module: `wel_gate`

## Requirements
- R1: After reset the status byte reads 0x00, no accept, reject or start pulse is present and `deep_sleep` is low. The status byte carries the write-enable latch (WEL) in bit 1 and the busy bit in bit 0, and bits 7..2 always read 0.
- R2: While awake and idle, opcode 0x06 is accepted and sets WEL, and opcode 0x04 is accepted and clears WEL.
- R3: The modifying opcodes are 0x0A (page write), 0x02 (page program), 0xE5 (lock-register write), 0xDB (page erase), 0xD8 (sector erase) and 0xC7 (bulk erase). Any of them is rejected while WEL is 0, and the status byte is left unchanged.
- R4: A modifying opcode whose bit count is zero or not a multiple of 8 is rejected, and WEL stays set.
- R5: A modifying opcode is rejected until INHIBIT_CYCLES clock cycles have passed after the internal reset release. Opcode 0x06 is still accepted during that window.
- R6: An accepted modifying opcode gives `seq_start` in the same cycle as `cmd_accept`, with `seq_op` equal to the opcode, and the busy bit reads 1 from that cycle on.
- R7: While the busy bit is set, the status read opcode 0x05 is accepted and every other opcode is rejected.
- R8: `seq_done` while busy clears both the busy bit and WEL in the next cycle. `seq_done` while idle changes nothing.
- R9: Opcode 0xB9 enters deep sleep (`deep_sleep` = 1) and leaves WEL as it was. In deep sleep every opcode except 0xAB is rejected, including 0x05 and 0x06. 0xAB is accepted and leaves deep sleep. When awake, 0xAB is accepted and has no effect.
- R10: Every strobe yields exactly one of `cmd_accept` or `cmd_reject`, as a one-cycle pulse in the next cycle, and no pulse appears without a strobe. An unlisted opcode (for example 0x77) is rejected. Read opcode 0x03 is accepted when awake and idle.
- R11: A strobe in the same cycle as `seq_done` is judged on the state before completion. It is therefore rejected, unless it is 0x05, and the status byte reads 0x00 afterwards.
- R12: Driving `rst_n` low clears WEL, the busy bit and deep sleep at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | One-cycle strobe: a decoded command is complete |
| cmd_op | input | 8 | Command opcode |
| cmd_bits | input | BITS_W | Number of clock pulses counted under chip select |
| seq_done | input | 1 | Completion pulse from the array sequencer |
| cmd_accept | output | 1 | Command accepted (one cycle) |
| cmd_reject | output | 1 | Command refused or ignored (one cycle) |
| seq_start | output | 1 | Start pulse to the array sequencer |
| seq_op | output | 8 | Opcode of the operation being started |
| status_byte | output | 8 | {6'b0, WEL, busy} |
| deep_sleep | output | 1 | Deep power-down state |

## Verification
The completion pulse and a new command strobe can arrive in the same cycle. The completion clears the busy bit and the latch, while the command is judged against the busy state that held before the edge. The bench provokes this twice. In the first case it pairs `seq_done` with a status read, which must be accepted. In the second it pairs `seq_done` with a write-enable, which must be rejected. In both cases the status byte must read 0x00 in the following cycle, so the write-enable neither survives nor resurrects the latch.

// File: rtl/wegate_pkg.sv
`timescale 1ns/1ps
package wegate_pkg;

  localparam int OP_W = 8;

  localparam logic [OP_W-1:0] OP_WREN  = 8'h06;
  localparam logic [OP_W-1:0] OP_WRDI  = 8'h04;
  localparam logic [OP_W-1:0] OP_RDSR  = 8'h05;
  localparam logic [OP_W-1:0] OP_READ  = 8'h03;
  localparam logic [OP_W-1:0] OP_PGWR  = 8'h0A;
  localparam logic [OP_W-1:0] OP_PGPR  = 8'h02;
  localparam logic [OP_W-1:0] OP_LKWR  = 8'hE5;
  localparam logic [OP_W-1:0] OP_PGER  = 8'hDB;
  localparam logic [OP_W-1:0] OP_SCER  = 8'hD8;
  localparam logic [OP_W-1:0] OP_BKER  = 8'hC7;
  localparam logic [OP_W-1:0] OP_SLEEP = 8'hB9;
  localparam logic [OP_W-1:0] OP_WAKE  = 8'hAB;

  typedef enum logic [2:0] {
    CL_NONE,
    CL_WREN,
    CL_WRDI,
    CL_STATUS,
    CL_READ,
    CL_MODIFY,
    CL_SLEEP,
    CL_WAKE
  } cmd_class_e;

endpackage

// File: rtl/wegate_rstsync.sv
`timescale 1ns/1ps
module wegate_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[N-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[N-1];
endmodule

// File: rtl/wegate_decode.sv
`timescale 1ns/1ps
module wegate_decode
  import wegate_pkg::*;
#(
  parameter int BITS_W    = 16,
  parameter int BYTE_BITS = 8
) (
  input  logic [OP_W-1:0]   op,
  input  logic [BITS_W-1:0] bits,
  output cmd_class_e        cls,
  output logic              whole_bytes
);
  localparam bit POW2  = (BYTE_BITS & (BYTE_BITS - 1)) == 0;
  localparam int LSB_W = (BYTE_BITS > 1) ? $clog2(BYTE_BITS) : 1;

  logic aligned;

  generate
    if (POW2 && BYTE_BITS > 1) begin : g_pow2
      assign aligned = (bits[LSB_W-1:0] == '0);
    end else begin : g_mod
      assign aligned = ((bits % BITS_W'(BYTE_BITS)) == '0);
    end
  endgenerate

  assign whole_bytes = aligned && (bits != '0);

  always_comb begin
    unique case (op)
      OP_WREN:  cls = CL_WREN;
      OP_WRDI:  cls = CL_WRDI;
      OP_RDSR:  cls = CL_STATUS;
      OP_READ:  cls = CL_READ;
      OP_PGWR, OP_PGPR, OP_LKWR,
      OP_PGER, OP_SCER, OP_BKER: cls = CL_MODIFY;
      OP_SLEEP: cls = CL_SLEEP;
      OP_WAKE:  cls = CL_WAKE;
      default:  cls = CL_NONE;
    endcase
  end
endmodule

// File: rtl/wegate_inhibit.sv
`timescale 1ns/1ps
module wegate_inhibit #(
  parameter int INHIBIT_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);
  generate
    if (INHIBIT_CYCLES == 0) begin : g_none
      assign ready = 1'b1;
    end else begin : g_cnt
      localparam int CNT_W = $clog2(INHIBIT_CYCLES + 1);
      localparam logic [CNT_W-1:0] LIMIT = CNT_W'(INHIBIT_CYCLES);

      logic [CNT_W-1:0] cnt_q, cnt_d;
      logic             cnt_en;

      assign ready  = (cnt_q == LIMIT);
      assign cnt_en = !ready;

      always_comb begin
        cnt_d = cnt_q;
        if (cnt_en) cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assert_ready_sticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
    end
  endgenerate
endmodule

// File: rtl/wegate_core.sv
`timescale 1ns/1ps
module wegate_core
  import wegate_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [OP_W-1:0] cmd_op,
  input  cmd_class_e      cls,
  input  logic            whole_bytes,
  input  logic            ready,
  input  logic            seq_done,
  output logic            acc_q,
  output logic            rej_q,
  output logic            start_q,
  output logic [OP_W-1:0] op_q,
  output logic            wel_q,
  output logic            wip_q,
  output logic            sleep_q
);
  logic ok;
  logic acc_d, rej_d, start_d;
  logic wel_d, wip_d, sleep_d;

  // Admission decision on the registered state.
  always_comb begin
    ok = 1'b0;
    if (sleep_q) begin
      ok = (cls == CL_WAKE);
    end else if (cls == CL_STATUS) begin
      ok = 1'b1;
    end else if (wip_q) begin
      ok = 1'b0;
    end else begin
      unique case (cls)
        CL_WREN, CL_WRDI, CL_READ, CL_SLEEP, CL_WAKE: ok = 1'b1;
        CL_MODIFY: ok = wel_q && whole_bytes && ready;
        default:   ok = 1'b0;
      endcase
    end
  end

  // Next state.
  always_comb begin
    acc_d   = cmd_valid && ok;
    rej_d   = cmd_valid && !ok;
    start_d = acc_d && (cls == CL_MODIFY);
    wel_d   = wel_q;
    wip_d   = wip_q;
    sleep_d = sleep_q;
    if (seq_done && wip_q) begin
      wip_d = 1'b0;
      wel_d = 1'b0;
    end
    if (acc_d) begin
      unique case (cls)
        CL_WREN:   wel_d   = 1'b1;
        CL_WRDI:   wel_d   = 1'b0;
        CL_SLEEP:  sleep_d = 1'b1;
        CL_WAKE:   sleep_d = 1'b0;
        CL_MODIFY: wip_d   = 1'b1;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= 1'b0;
      rej_q   <= 1'b0;
      start_q <= 1'b0;
      wel_q   <= 1'b0;
      wip_q   <= 1'b0;
      sleep_q <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      rej_q   <= rej_d;
      start_q <= start_d;
      wel_q   <= wel_d;
      wip_q   <= wip_d;
      sleep_q <= sleep_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       op_q <= '0;
    else if (start_d) op_q <= cmd_op;
  end

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (acc_q ^ rej_q));
  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !(acc_q || rej_q));
  assert_start_with_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> acc_q);
  assert_busy_from_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip_q) |-> start_q);
  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wip_q && cmd_valid && cls != CL_STATUS) |=> rej_q);
  assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wip_q && seq_done) |=> !(wip_q || wel_q));
  assert_sleep_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_q && cmd_valid && cls != CL_WAKE) |=> rej_q);
  assert_need_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cls == CL_MODIFY && !wel_q) |=> (rej_q && !start_q));
  assert_whole_bytes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cls == CL_MODIFY && !whole_bytes) |=> (rej_q && !start_q));
  assert_inhibit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !ready) |=> !start_q);
endmodule

// File: rtl/wel_gate.sv
`timescale 1ns/1ps
module wel_gate
  import wegate_pkg::*;
#(
  parameter int BITS_W         = 16,
  parameter int BYTE_BITS      = 8,
  parameter int INHIBIT_CYCLES = 1024,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [BITS_W-1:0] cmd_bits,
  input  logic              seq_done,
  output logic              cmd_accept,
  output logic              cmd_reject,
  output logic              seq_start,
  output logic [7:0]        seq_op,
  output logic [7:0]        status_byte,
  output logic              deep_sleep
);
  localparam int STATUS_W = 8;

  logic       rst_sync_n;
  cmd_class_e cls;
  logic       whole_bytes;
  logic       ready;
  logic       wel, wip;

  wegate_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  wegate_decode #(.BITS_W(BITS_W), .BYTE_BITS(BYTE_BITS)) u_dec (
    .op(cmd_op), .bits(cmd_bits), .cls(cls), .whole_bytes(whole_bytes)
  );

  wegate_inhibit #(.INHIBIT_CYCLES(INHIBIT_CYCLES)) u_inh (
    .clk(clk), .rst_n(rst_sync_n), .ready(ready)
  );

  wegate_core u_core (
    .clk(clk), .rst_n(rst_sync_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cls(cls),
    .whole_bytes(whole_bytes), .ready(ready), .seq_done(seq_done),
    .acc_q(cmd_accept), .rej_q(cmd_reject), .start_q(seq_start),
    .op_q(seq_op), .wel_q(wel), .wip_q(wip), .sleep_q(deep_sleep)
  );

  assign status_byte = {{(STATUS_W-2){1'b0}}, wel, wip};
endmodule

// File: tb/wel_gate_test.sv
`timescale 1ns/1ps
module wel_gate_test;
  localparam logic [7:0] K_WREN = 8'h06, K_WRDI = 8'h04, K_RDSR = 8'h05,
                         K_READ = 8'h03, K_PGWR = 8'h0A, K_PGPR = 8'h02,
                         K_LKWR = 8'hE5, K_PGER = 8'hDB, K_SCER = 8'hD8,
                         K_BKER = 8'hC7, K_DP   = 8'hB9, K_WAKE = 8'hAB;
  localparam logic [1:0] NONE = 2'd0, ACC = 2'd1, REJ = 2'd2;

  typedef struct packed {
    logic       valid;
    logic [7:0] op;
    logic [15:0] bits;
    logic       done;
    logic [1:0] outc;
    logic [1:0] st;
    logic       start;
    logic       sleep;
    logic [3:0] rq;
  } vec_t;

  function automatic vec_t mk(logic v, logic [7:0] op, logic [15:0] b, logic d,
                              logic [1:0] o, logic [1:0] s, logic st, logic sl,
                              logic [3:0] rq);
    return '{valid: v, op: op, bits: b, done: d, outc: o, st: s,
             start: st, sleep: sl, rq: rq};
  endfunction

  localparam int NV = 30;
  localparam vec_t TBL [NV] = '{
    mk(1, K_WRDI, 8,  0, ACC, 2'd0, 0, 0, 2),   // R2 clear latch
    mk(1, K_PGPR, 32, 0, REJ, 2'd0, 0, 0, 3),   // R3 no latch
    mk(1, K_WREN, 8,  0, ACC, 2'd2, 0, 0, 2),   // R2 set latch
    mk(1, K_PGPR, 13, 0, REJ, 2'd2, 0, 0, 4),   // R4 odd bits
    mk(1, K_PGPR, 0,  0, REJ, 2'd2, 0, 0, 4),   // R4 zero bits
    mk(1, K_PGPR, 32, 0, ACC, 2'd3, 1, 0, 6),   // R6 start
    mk(1, K_WREN, 8,  0, REJ, 2'd3, 0, 0, 7),   // R7 busy
    mk(1, K_RDSR, 8,  0, ACC, 2'd3, 0, 0, 7),   // R7 status read
    mk(1, K_READ, 32, 0, REJ, 2'd3, 0, 0, 7),   // R7 busy read
    mk(0, 8'h00,  0,  1, NONE,2'd0, 0, 0, 8),   // R8 completion
    mk(0, 8'h00,  0,  1, NONE,2'd0, 0, 0, 8),   // R8 idle completion
    mk(1, K_WREN, 8,  0, ACC, 2'd2, 0, 0, 2),   // R2
    mk(1, K_WRDI, 8,  0, ACC, 2'd0, 0, 0, 2),   // R2
    mk(1, 8'h77,  8,  0, REJ, 2'd0, 0, 0, 10),  // R10 unknown
    mk(1, K_READ, 32, 0, ACC, 2'd0, 0, 0, 10),  // R10 read
    mk(1, K_DP,   8,  0, ACC, 2'd0, 0, 1, 9),   // R9 enter sleep
    mk(1, K_RDSR, 8,  0, REJ, 2'd0, 0, 1, 9),   // R9
    mk(1, K_WREN, 8,  0, REJ, 2'd0, 0, 1, 9),   // R9
    mk(1, K_WAKE, 8,  0, ACC, 2'd0, 0, 0, 9),   // R9 wake
    mk(1, K_WREN, 8,  0, ACC, 2'd2, 0, 0, 2),   // R2
    mk(1, K_DP,   8,  0, ACC, 2'd2, 0, 1, 9),   // R9 latch kept
    mk(1, K_SCER, 32, 0, REJ, 2'd2, 0, 1, 9),   // R9
    mk(1, K_WAKE, 8,  0, ACC, 2'd2, 0, 0, 9),   // R9
    mk(1, K_SCER, 32, 0, ACC, 2'd3, 1, 0, 6),   // R6
    mk(1, K_RDSR, 8,  1, ACC, 2'd0, 0, 0, 11),  // R11 status with done
    mk(1, K_WREN, 8,  0, ACC, 2'd2, 0, 0, 2),   // R2
    mk(1, K_BKER, 8,  0, ACC, 2'd3, 1, 0, 6),   // R6
    mk(1, K_WREN, 8,  1, REJ, 2'd0, 0, 0, 11),  // R11 enable with done
    mk(1, K_WAKE, 8,  0, ACC, 2'd0, 0, 0, 9),   // R9 wake while awake
    mk(0, 8'h00,  0,  0, NONE,2'd0, 0, 0, 10)   // R10 quiet
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, seq_done;
  logic [7:0]  cmd_op;
  logic [15:0] cmd_bits;
  logic        cmd_accept, cmd_reject, seq_start, deep_sleep;
  logic [7:0]  seq_op, status_byte;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  wel_gate #(.BITS_W(16), .INHIBIT_CYCLES(12)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bits(cmd_bits), .seq_done(seq_done), .cmd_accept(cmd_accept),
    .cmd_reject(cmd_reject), .seq_start(seq_start), .seq_op(seq_op),
    .status_byte(status_byte), .deep_sleep(deep_sleep)
  );

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] op,
                      input logic [15:0] b, input logic d);
    cmd_valid = v; cmd_op = op; cmd_bits = b; seq_done = d;
    @(negedge clk);
    cmd_valid = 1'b0; seq_done = 1'b0;
  endtask

  function automatic logic [1:0] outcome();
    return {cmd_reject, cmd_accept};
  endfunction

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; seq_done = 1'b0; cmd_op = '0; cmd_bits = '0;
    repeat (4) @(negedge clk);
    check("R1", "reset status", status_byte, 8'h00);
    check("R1", "reset pulses", {cmd_accept, cmd_reject, seq_start, deep_sleep}, 4'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5: inside the inhibit window
    step(1, K_WREN, 8, 0);
    check("R5", "enable in window", outcome(), ACC);
    step(1, K_PGPR, 32, 0);
    check("R5", "modify in window", outcome(), REJ);
    check("R5", "no start in window", seq_start, 1'b0);
    check("R5", "status in window", status_byte, 8'h02);
    repeat (20) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", TBL[i].rq);
      step(TBL[i].valid, TBL[i].op, TBL[i].bits, TBL[i].done);
      check(tag, $sformatf("vec%0d outcome", i), outcome(), TBL[i].outc);
      check(tag, $sformatf("vec%0d status", i), status_byte, {6'b0, TBL[i].st});
      check(tag, $sformatf("vec%0d start", i), seq_start, TBL[i].start);
      check(tag, $sformatf("vec%0d sleep", i), deep_sleep, TBL[i].sleep);
      if (TBL[i].start) check(tag, $sformatf("vec%0d seq_op", i), seq_op, TBL[i].op);
    end

    // R3 / R6 / R8: every modifying opcode
    begin
      logic [7:0] mods [6];
      mods = '{K_PGWR, K_PGPR, K_LKWR, K_PGER, K_SCER, K_BKER};
      foreach (mods[k]) begin
        step(1, mods[k], 40, 0);
        check("R3", "modify without latch", outcome(), REJ);
        step(1, K_WREN, 8, 0);
        step(1, mods[k], 40, 0);
        check("R6", "modify accepted", {seq_start, outcome()}, {1'b1, ACC});
        check("R6", "seq_op", seq_op, mods[k]);
        check("R6", "busy status", status_byte, 8'h03);
        step(0, 8'h00, 0, 1);
        check("R8", "after completion", status_byte, 8'h00);
      end
    end

    // R12: asynchronous reset with latch set and asleep
    step(1, K_WREN, 8, 0);
    step(1, K_DP, 8, 0);
    check("R12", "pre-reset sleep", deep_sleep, 1'b1);
    #1 rst_n = 1'b0;
    #0.5;
    check("R12", "status after reset", status_byte, 8'h00);
    check("R12", "sleep after reset", deep_sleep, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule